// File: doc/BRIEF.md
# Processor Activity Watchdog with Run-Time Period Choice

This block watches a strobe line toggled by software running on a processor. The processor shows that it is alive by driving the line from high to low. If no such falling edge arrives within the chosen window, the block raises a single-cycle expiry pulse. A reset generator outside this block turns that pulse into a stretched system reset. The window is counted in ticks of a 1 ms enable. A two-bit select picks one of three lengths: short (150 ticks), medium (600 ticks) or long (1200 ticks).

The strobe is asynchronous to the clock. It passes through a flop synchroniser, and edge detection uses the synchronised copy. A falling edge always restarts a full window. Rising edges and steady levels do nothing. While the reset generator holds its reset-active input high, the window counter stays at zero and no expiry is produced. When that input is released, a fresh window starts. The block has no data stream, so none of its pins uses a valid/ready handshake. Every pin is a plain level or a single-cycle pulse, with no back-pressure.

Top module: `proc_watchdog`

## Requirements
- R1: While `hold_in_reset` is 1, `expire_pulse` stays 0 and the count is cleared. A full window starts with the first clock after release, so with a tick on every clock the first expiry comes L clocks after release, where L is the selected length in ticks.
- R2: Select value 2'b00 gives a window of 150 ticks.
- R3: Select value 2'b01 gives a window of 600 ticks.
- R4: Select values 2'b10 and 2'b11 both give a window of 1200 ticks.
- R5: A falling edge on `wd_strobe_async` restarts the full window. With the default two synchroniser stages, the restart lands on the third clock edge after the edge. With ticks on every clock, the next expiry is then L clocks after that restart.
- R6: A rising edge, or a strobe held at either level, never restarts the window.
- R7: `expire_pulse` is high for exactly one clock. That expiry also restarts the window, so with no strobe activity the expiries repeat every L ticks.
- R8: The count advances only on clocks where `tick_1ms` is 1. Clocks without a tick neither advance the count nor cause an expiry.
- R9: The select is sampled only at a window start: a release from hold, a strobe restart, or an expiry. A change made part-way through a window takes effect from the next window.
- R10: If a strobe restart falls on the same clock as the final tick of a window, the restart wins and no expiry is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| tick_1ms | input | 1 | Count enable, one clock wide every millisecond |
| wd_strobe_async | input | 1 | Processor activity strobe; a falling edge restarts the window |
| period_sel | input | 2 | Window select: 00 short, 01 medium, 10/11 long |
| hold_in_reset | input | 1 | Reset-active flag from the reset generator; clears and holds the count |
| expire_pulse | output | 1 | One-clock pulse when a window ends with no strobe restart |

## Verification
The case that is hardest to reach from the ports is a strobe restart landing on exactly the same clock as the last tick of a window. That clock sits behind the synchroniser delay, which cannot be seen from outside. The bench reaches it by lowering the strobe three clocks before the computed expiry clock, so the restart lands on the final tick. It then expects the next expiry one full window later, and it flags any pulse near the original deadline. A mid-window change of the select is handled the same way: the bench expects the old length once and the new length only after the next window start.

// File: rtl/proc_watchdog_pkg.sv
package proc_watchdog_pkg;

  typedef enum logic [1:0] {
    WIN_SHORT    = 2'b00,
    WIN_MEDIUM   = 2'b01,
    WIN_LONG     = 2'b10,
    WIN_LONG_ALT = 2'b11
  } win_sel_e;

endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic hold,
  input  logic strobe_async,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk) chain[0] <= strobe_async;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) chain[i] <= chain[i-1];
    end
  endgenerate

  always_ff @(posedge clk) prev_q <= chain[STAGES-1];

  assign fall = prev_q & ~chain[STAGES-1];

  // R5: a detected falling edge lasts one clock
  a_r5_fall_single: assert property (@(posedge clk) disable iff (hold)
    fall |=> !fall);

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import proc_watchdog_pkg::*;
#(
  parameter int CNT_W        = 11,
  parameter int SHORT_TICKS  = 150,
  parameter int MEDIUM_TICKS = 600,
  parameter int LONG_TICKS   = 1200
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] limit
);

  always_comb begin
    unique case (win_sel_e'(sel))
      WIN_SHORT:    limit = CNT_W'(SHORT_TICKS);
      WIN_MEDIUM:   limit = CNT_W'(MEDIUM_TICKS);
      WIN_LONG:     limit = CNT_W'(LONG_TICKS);
      WIN_LONG_ALT: limit = CNT_W'(LONG_TICKS);
      default:      limit = CNT_W'(LONG_TICKS);
    endcase
  end

endmodule

// File: rtl/wdt_window_counter.sv
module wdt_window_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit_in,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             last_tick;

  assign last_tick = tick && (cnt_q == lim_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt_q  <= '0;
      lim_q  <= limit_in;
      expire <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      lim_q  <= limit_in;
      expire <= 1'b0;
    end else if (last_tick) begin
      cnt_q  <= '0;
      lim_q  <= limit_in;
      expire <= 1'b1;
    end else if (tick) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
    end
  end

  // R1: hold keeps the output quiet and the count cleared
  a_r1_quiet_in_hold: assert property (@(posedge clk)
    hold |=> (!expire && cnt_q == '0));

  // R5 / R10: a restart clears the count and suppresses expiry
  a_r10_restart_wins: assert property (@(posedge clk) disable iff (hold)
    restart |=> (cnt_q == '0 && !expire));

  // R7: expiry is a single-clock pulse
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (hold)
    expire |=> !expire);

  // R8: no tick, no restart -> count frozen
  a_r8_stall: assert property (@(posedge clk) disable iff (hold)
    (!tick && !restart) |=> $stable(cnt_q));

  // R9: latched length moves only at a window start
  a_r9_limit_latched: assert property (@(posedge clk) disable iff (hold)
    (!restart && !last_tick) |=> $stable(lim_q));

endmodule

// File: rtl/proc_watchdog.sv
module proc_watchdog #(
  parameter int SYNC_STAGES  = 2,
  parameter int SHORT_TICKS  = 150,
  parameter int MEDIUM_TICKS = 600,
  parameter int LONG_TICKS   = 1200
) (
  input  logic       clk,
  input  logic       tick_1ms,
  input  logic       wd_strobe_async,
  input  logic [1:0] period_sel,
  input  logic       hold_in_reset,
  output logic       expire_pulse
);

  localparam int MAX_A = (SHORT_TICKS > MEDIUM_TICKS) ? SHORT_TICKS : MEDIUM_TICKS;
  localparam int MAX_TICKS = (MAX_A > LONG_TICKS) ? MAX_A : LONG_TICKS;
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic             strobe_fall;
  logic [CNT_W-1:0] sel_limit;

  wdt_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .hold         (hold_in_reset),
    .strobe_async (wd_strobe_async),
    .fall         (strobe_fall)
  );

  wdt_period_sel #(
    .CNT_W        (CNT_W),
    .SHORT_TICKS  (SHORT_TICKS),
    .MEDIUM_TICKS (MEDIUM_TICKS),
    .LONG_TICKS   (LONG_TICKS)
  ) u_sel (
    .sel   (period_sel),
    .limit (sel_limit)
  );

  wdt_window_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .hold     (hold_in_reset),
    .tick     (tick_1ms),
    .restart  (strobe_fall),
    .limit_in (sel_limit),
    .expire   (expire_pulse)
  );

endmodule

// File: tb/proc_watchdog_tb.sv
module proc_watchdog_tb;

  typedef struct {
    int    at;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       tick_1ms = 1'b1;
  logic       wd_strobe_async = 1'b1;
  logic [1:0] period_sel = 2'b00;
  logic       hold_in_reset = 1'b1;
  logic       expire_pulse;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  proc_watchdog u_dut (
    .clk             (clk),
    .tick_1ms        (tick_1ms),
    .wd_strobe_async (wd_strobe_async),
    .period_sel      (period_sel),
    .hold_in_reset   (hold_in_reset),
    .expire_pulse    (expire_pulse)
  );

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!done) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        checks++; fails++;
        $display("FAIL %s: missing expiry, actual none, expected cycle %0d", q[0].tag, q[0].at);
        void'(q.pop_front());
      end
      if (expire_pulse) begin
        checks++;
        if (q.size() > 0 && q[0].at == cyc) begin
          void'(q.pop_front());
        end else begin
          fails++;
          $display("FAIL %s: unexpected expiry, actual cycle %0d, expected %0d",
                   (q.size() > 0) ? q[0].tag : "R6/R10", cyc,
                   (q.size() > 0) ? q[0].at : -1);
        end
      end
    end
  end

  task automatic push_exp(input int at, input string tag);
    exp_t e;
    e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic enter_hold(input logic [1:0] sel, input logic lvl);
    @(negedge clk);
    hold_in_reset = 1'b1; period_sel = sel; wd_strobe_async = lvl; tick_1ms = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (expire_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R1: expiry during hold, actual %b expected 0", expire_pulse);
    end
  endtask

  task automatic release_hold(output int c0);
    hold_in_reset = 1'b0;
    c0 = cyc;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    int c0;
    // R1 / R2 / R7: short window, periodic
    enter_hold(2'b00, 1'b1);
    release_hold(c0);
    push_exp(c0 + 150, "R2");
    push_exp(c0 + 300, "R7");
    wait_until(c0 + 301);
    // R3
    enter_hold(2'b01, 1'b1);
    release_hold(c0);
    push_exp(c0 + 600, "R3");
    wait_until(c0 + 601);
    // R4: 10 and 11
    enter_hold(2'b10, 1'b1);
    release_hold(c0);
    push_exp(c0 + 1200, "R4");
    wait_until(c0 + 1201);
    enter_hold(2'b11, 1'b1);
    release_hold(c0);
    push_exp(c0 + 1200, "R4");
    wait_until(c0 + 1201);
    // R5: two falls restart, rises ignored
    enter_hold(2'b00, 1'b1);
    release_hold(c0);
    push_exp(c0 + 273, "R5");
    wait_until(c0 + 100); wd_strobe_async = 1'b0;
    wait_until(c0 + 110); wd_strobe_async = 1'b1;
    wait_until(c0 + 120); wd_strobe_async = 1'b0;
    wait_until(c0 + 130); wd_strobe_async = 1'b1;
    wait_until(c0 + 274);
    // R6: low level through release, rise mid-window
    enter_hold(2'b00, 1'b0);
    release_hold(c0);
    push_exp(c0 + 150, "R6");
    push_exp(c0 + 300, "R6");
    wait_until(c0 + 100); wd_strobe_async = 1'b1;
    wait_until(c0 + 301);
    // R8: tick gating
    enter_hold(2'b00, 1'b1);
    release_hold(c0);
    push_exp(c0 + 1150, "R8");
    wait_until(c0 + 10); tick_1ms = 1'b0;
    wait_until(c0 + 1010); tick_1ms = 1'b1;
    wait_until(c0 + 1151);
    // R9: select change mid-window
    enter_hold(2'b00, 1'b1);
    release_hold(c0);
    push_exp(c0 + 150, "R9");
    push_exp(c0 + 1350, "R9");
    wait_until(c0 + 50); period_sel = 2'b10;
    wait_until(c0 + 1351);
    // R10: restart on the final tick
    enter_hold(2'b00, 1'b1);
    release_hold(c0);
    push_exp(c0 + 300, "R10");
    wait_until(c0 + 147); wd_strobe_async = 1'b0;
    wait_until(c0 + 301);
    enter_hold(2'b00, 1'b1);
    repeat (2) @(negedge clk);
    done = 1'b1;
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7: pending expiries, actual %0d expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule